// File: doc/BRIEF.md
# Data Block Gap Timeout Counter

This block measures how long a card interface has been waiting for the next data block. It counts card clock edges, which arrive as a one-cycle strobe on the system clock. It raises an error once the wait reaches a programmed limit. The limit is a 4-bit cycle count multiplied by a factor. The factor is picked by a 3-bit code from a fixed table that runs from 1 up to 2^20.

The limit is built in two stages. A prescaler counts card clock edges up to the selected factor. A small counter then counts the prescaler wraps and compares them with the cycle count. Both stages return to zero on every block start. Counting only advances while the interface is armed and a card clock edge arrives. If the card clock stops, the timeout pauses.

The error flag is sticky. It stays set, and counting stays frozen, until a clear arrives. A one-cycle expiry pulse marks the cycle in which the flag rises.

Top module: `dto_timer`

## Requirements
- R1: After reset, `timeout_o` and `expire_o` are low and all count progress is zero.
- R2: With `cyc_i` nonzero, `timeout_o` rises right after exactly `cyc_i` × M counted edges. M is set by `mul_i` as follows: 0→1, 1→16, 2→128, 3→256, 4→1024, 5→4096, 6→65536, 7→1048576.
- R3: With `cyc_i` equal to 0, the first counted edge sets `timeout_o`, whatever the value of `mul_i`.
- R4: An edge is counted only in a cycle where `arm_i` and `tick_i` are both high. In any other cycle, count progress holds.
- R5: `restart_i` returns count progress to zero and takes priority over a tick in the same cycle. It does not change `timeout_o`.
- R6: Once set, `timeout_o` stays high until `clear_i` is asserted, and counting stays stopped in the meantime.
- R7: `clear_i` lowers `timeout_o` and returns count progress to zero. It takes priority over an expiry in the same cycle.
- R8: `expire_o` is high for exactly the one cycle in which `timeout_o` rises.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| tick_i | input | 1 | One-cycle strobe for each card clock edge |
| arm_i | input | 1 | High while the interface is waiting for a data block |
| restart_i | input | 1 | Pulse at each block start; restarts the count |
| clear_i | input | 1 | Clears the error flag and the count |
| cyc_i | input | 4 | Cycle count of the limit |
| mul_i | input | 3 | Multiplier code |
| timeout_o | output | 1 | Sticky timeout error flag |
| expire_o | output | 1 | One-cycle pulse when the limit is reached |

## Verification
A wrong prescaler wrap point or a miscounted wrap shows up as `timeout_o` rising early or late, scaled by the factor. For that reason every multiplier code that fits in the run is timed to the exact edge. A counter that fails to hold or to restart shows as a shifted rise, within one limit period of the paused or restarted stretch. A flag that is not sticky, or that clears wrongly, shows in the cycle after the causing input.

// File: rtl/dto_pkg.sv
package dto_pkg;
  localparam int unsigned CYC_W = 4;
  localparam int unsigned CODE_W = 3;
  localparam int unsigned PRE_W = 20;

  // last prescaler value (factor - 1) for a multiplier code
  function automatic logic [PRE_W-1:0] pre_last(input logic [CODE_W-1:0] code);
    int unsigned sh;
    case (code)
      3'd0: sh = 0;
      3'd1: sh = 4;
      3'd2: sh = 7;
      3'd3: sh = 8;
      3'd4: sh = 10;
      3'd5: sh = 12;
      3'd6: sh = 16;
      default: sh = 20;
    endcase
    pre_last = PRE_W'((64'd1 << sh) - 64'd1);
  endfunction
endpackage

// File: rtl/dto_prescale.sv
module dto_prescale
  import dto_pkg::*;
(
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              adv_i,
  input  logic              zero_i,
  input  logic [CODE_W-1:0] code_i,
  output logic              wrap_o
);
  logic [PRE_W-1:0] pre_q;
  logic [PRE_W-1:0] last;

  assign last   = pre_last(code_i);
  assign wrap_o = adv_i && (pre_q >= last);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)       pre_q <= '0;
    else if (zero_i)   pre_q <= '0;
    else if (wrap_o)   pre_q <= '0;
    else if (adv_i)    pre_q <= pre_q + 1'b1;
  end

  assert_pre_hold_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!adv_i && !zero_i) |=> $stable(pre_q));
  assert_pre_zero_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    zero_i |=> (pre_q == '0));
endmodule

// File: rtl/dto_wrap_cnt.sv
module dto_wrap_cnt
  import dto_pkg::*;
(
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             wrap_i,
  input  logic             zero_i,
  input  logic [CYC_W-1:0] cyc_i,
  output logic             hit_o
);
  logic [CYC_W-1:0] cnt_q;
  logic [CYC_W:0]   next_cnt;

  assign next_cnt = {1'b0, cnt_q} + 1'b1;
  assign hit_o    = wrap_i && (next_cnt >= {1'b0, cyc_i});

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)      cnt_q <= '0;
    else if (zero_i)  cnt_q <= '0;
    else if (wrap_i)  cnt_q <= next_cnt[CYC_W-1:0];
  end

  assert_cnt_hold_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!wrap_i && !zero_i) |=> $stable(cnt_q));
  assert_cnt_zero_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    zero_i |=> (cnt_q == '0));
endmodule

// File: rtl/dto_timer.sv
module dto_timer
  import dto_pkg::*;
(
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              tick_i,
  input  logic              arm_i,
  input  logic              restart_i,
  input  logic              clear_i,
  input  logic [CYC_W-1:0]  cyc_i,
  input  logic [CODE_W-1:0] mul_i,
  output logic              timeout_o,
  output logic              expire_o
);
  logic timeout_q, expire_q;
  logic zero, adv, wrap, hit, expire_d;

  assign zero = restart_i || clear_i;
  // frozen while flagged; restart/clear win over a tick
  assign adv  = arm_i && tick_i && !timeout_q && !zero;

  dto_prescale u_pre (
    .clk_i (clk_i), .rst_ni(rst_ni), .adv_i(adv), .zero_i(zero),
    .code_i(mul_i), .wrap_o(wrap)
  );

  dto_wrap_cnt u_cnt (
    .clk_i (clk_i), .rst_ni(rst_ni), .wrap_i(wrap), .zero_i(zero),
    .cyc_i (cyc_i), .hit_o(hit)
  );

  assign expire_d = adv && ((cyc_i == '0) || hit);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      timeout_q <= 1'b0;
      expire_q  <= 1'b0;
    end else begin
      expire_q <= expire_d && !clear_i;
      if (clear_i)       timeout_q <= 1'b0;
      else if (expire_d) timeout_q <= 1'b1;
    end
  end

  assign timeout_o = timeout_q;
  assign expire_o  = expire_q;

  assert_sticky_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (timeout_o && !clear_i) |=> timeout_o);
  assert_clear_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    clear_i |=> !timeout_o);
  assert_expire_rise_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    expire_o |-> (timeout_o && !$past(timeout_o)));
  assert_expire_single_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    expire_o |=> !expire_o);
  assert_no_count_idle_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!timeout_o && !(arm_i && tick_i) && !clear_i) |=> !expire_o);
endmodule

// File: tb/dto_timer_bench.sv
module dto_timer_bench;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic tick = 1'b0, arm = 1'b0, restart = 1'b0, clear = 1'b0;
  logic [3:0] cyc = '0;
  logic [2:0] mul = '0;
  logic timeout, expire;
  int checks = 0, errors = 0;

  always #4 clk = ~clk;

  dto_timer u_dto_timer (
    .clk_i(clk), .rst_ni(rst_n), .tick_i(tick), .arm_i(arm),
    .restart_i(restart), .clear_i(clear), .cyc_i(cyc), .mul_i(mul),
    .timeout_o(timeout), .expire_o(expire)
  );

  // {cyc, code, expected counted edges}
  localparam logic [27:0] VEC [10] = '{
    {4'd3,  3'd0, 21'd3},     {4'd15, 3'd0, 21'd15},
    {4'd2,  3'd1, 21'd32},    {4'd1,  3'd2, 21'd128},
    {4'd3,  3'd3, 21'd768},   {4'd2,  3'd4, 21'd2048},
    {4'd1,  3'd5, 21'd4096},  {4'd1,  3'd6, 21'd65536},
    {4'd0,  3'd6, 21'd1},     {4'd0,  3'd0, 21'd1}
  };

  task automatic chk(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic do_clear();
    @(negedge clk); clear = 1'b1; tick = 1'b0;
    @(negedge clk); clear = 1'b0;
  endtask

  // ticks every cycle; returns counted edges until flag seen
  task automatic run_until(input int limit, output int n, output logic exp_seen);
    n = 0; exp_seen = 1'b0;
    tick = 1'b1; arm = 1'b1;
    while (n < limit) begin
      @(posedge clk); n++;
      @(negedge clk);
      if (timeout) begin exp_seen = expire; break; end
    end
    tick = 1'b0;
  endtask

  initial begin
    int n;
    logic es;
    #2000000;
    errors++;
    $display("FAIL watchdog actual 1 expected 0");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    int n;
    logic es;
    repeat (3) @(negedge clk);
    chk("R1 timeout", int'(timeout), 0);
    chk("R1 expire", int'(expire), 0);
    rst_n = 1'b1;
    @(negedge clk);

    for (int i = 0; i < 10; i++) begin
      cyc = VEC[i][27:24]; mul = VEC[i][23:21];
      do_clear();
      run_until(int'(VEC[i][20:0]) + 4, n, es);
      chk((VEC[i][27:24] == 0) ? "R3 zero cycle count" : "R2 limit", n, int'(VEC[i][20:0]));
      chk("R8 pulse at rise", int'(es), 1);
      @(negedge clk);
      chk("R8 pulse one cycle", int'(expire), 0);
    end

    // R6: sticky with arm dropped and ticks running
    arm = 1'b0; tick = 1'b1;
    repeat (5) @(negedge clk);
    chk("R6 sticky", int'(timeout), 1);
    // R5: restart leaves flag
    restart = 1'b1; @(negedge clk); restart = 1'b0; @(negedge clk);
    chk("R5 restart keeps flag", int'(timeout), 1);
    tick = 1'b0;
    // R7 clear drops flag
    do_clear();
    chk("R7 clear", int'(timeout), 0);

    // R4: ticks without arm do nothing
    cyc = 4'd4; mul = 3'd0;
    arm = 1'b0; tick = 1'b1;
    repeat (20) @(negedge clk);
    chk("R4 unarmed", int'(timeout), 0);
    // armed but no tick
    arm = 1'b1; tick = 1'b0;
    repeat (20) @(negedge clk);
    chk("R4 no tick", int'(timeout), 0);
    // R4: every other cycle ticks, 4 edges -> flag after 4th counted
    n = 0;
    for (int k = 0; k < 20; k++) begin
      tick = k[0];
      @(negedge clk);
      if (k[0]) n++;
      if (timeout) break;
    end
    tick = 1'b0;
    chk("R4 gapped ticks", n, 4);

    // R5: restart mid count: 5 edges, restart, then need 8 more
    do_clear();
    cyc = 4'd8; mul = 3'd0;
    run_until(5, n, es);
    chk("R5 before restart", int'(timeout), 0);
    restart = 1'b1; tick = 1'b1;
    @(negedge clk); restart = 1'b0;
    run_until(20, n, es);
    chk("R5 after restart", n, 8);

    // R7: clear mid count zeros progress; R7 clear wins over expiry
    do_clear();
    cyc = 4'd3;
    run_until(2, n, es);
    @(negedge clk); clear = 1'b1; tick = 1'b1; arm = 1'b1;
    @(negedge clk); clear = 1'b0; tick = 1'b0;
    chk("R7 clear wins expiry", int'(timeout), 0);
    run_until(20, n, es);
    chk("R7 progress zeroed", n, 3);

    // R2: code 7 partial, no flag after 3000 edges
    do_clear();
    cyc = 4'd1; mul = 3'd7;
    run_until(3000, n, es);
    chk("R2 code 7 not early", int'(timeout), 0);

    // R1: reset mid flag
    do_clear();
    cyc = 4'd1; mul = 3'd0;
    run_until(5, n, es);
    rst_n = 1'b0; @(negedge clk);
    chk("R1 reset clears flag", int'(timeout), 0);
    rst_n = 1'b1;

    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule